// File: doc/BRIEF.md
# Switchable Dual-Modulus Clock Prescaler

This block divides a fast input clock by one of four ratios: 64, 65, 128 or 129. One control pin, `range_narrow`, chooses the ratio family. When it is high the ratio is 64 or 65, and when it is low the ratio is 128 or 129. A second pin, `mod_base`, chooses within that family. When it is high the ratio is the base value N, and when it is low the ratio is N+1. The output makes exactly one rising edge per division cycle. It is intended to clock a positive-edge-triggered counter further down the chain, for example the program and swallow counters of a frequency synthesizer.

The controls are not used directly. Once per output period, a fixed number of input clocks (`SAMPLE_LEAD` + 1) before that period ends, the block copies both controls into a pending register. The period that starts next uses the pending value. As a result, a change on the controls always takes effect on a whole period and never shortens or stretches the period already running. The output is registered. It is high for the first floor(P/2) clocks of a P-clock period and low for the remaining clocks.

A synchronous active-high reset clears the phase counter and forces the output low. While reset is held, both the running ratio and the pending ratio follow the live controls. The first period after reset therefore uses the control values present on the last reset clock.

Top module: `dual_modulus_prescaler`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pulse_out` is low after that edge.
- R2: With `range_narrow`=1 and `mod_base`=1, rising edges of `pulse_out` are exactly 64 clocks apart.
- R3: With `range_narrow`=1 and `mod_base`=0, rising edges of `pulse_out` are exactly 65 clocks apart.
- R4: With `range_narrow`=0 and `mod_base`=1, rising edges of `pulse_out` are exactly 128 clocks apart.
- R5: With `range_narrow`=0 and `mod_base`=0, rising edges of `pulse_out` are exactly 129 clocks apart.
- R6: Each period of P clocks has exactly one rising edge. `pulse_out` is high for floor(P/2) clocks, starting one clock after the period's counter reaches zero, and low for the other clocks.
- R7: A control change made early in a period does not alter that period's length. It sets the length of the following period.
- R8: Controls are sampled on the single clock edge at which the phase counter equals P-1-`SAMPLE_LEAD`. The counter reads 1 just after the rising edge, so this is the (P-1-`SAMPLE_LEAD`)-th edge counted from that rising edge. A change seen first at that edge applies to the next period. A change seen first one edge later is deferred by one further period.
- R9: After reset is released, the first rising edge of `pulse_out` occurs at the first clock edge. The first period uses the controls that were present while reset was held.
- R10: When the controls change in every period, each measured period matches the controls set during the period before it, with no period lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| range_narrow | input | 1 | Ratio family: 1 = 64/65, 0 = 128/129 |
| mod_base | input | 1 | Ratio within family: 1 = N, 0 = N+1 |
| pulse_out | output | 1 | Divided clock, one rising edge per period |

## Verification
Two events can fall on the same input clock: a change on the controls, and the single edge at which those controls are sampled into the pending register. The bench places a control change so that it is seen first exactly on the sampling edge, and then so that it is seen first one edge later. It judges the result by counting clocks between successive rising output edges: the first placement must alter the very next period, and the second must alter the period after it. The bench also asserts reset inside the output's high phase and checks that the restart uses the controls held during reset.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Control pair as seen on the pins.
  typedef struct packed {
    logic narrow;     // 1: small family, 0: large family
    logic base_only;  // 1: N, 0: N+1
  } psc_ctl_t;

  // Period length in input clocks for a control pair.
  function automatic int unsigned period_len(psc_ctl_t c, int unsigned lo_base,
                                             int unsigned hi_base);
    int unsigned b;
    b = c.narrow ? lo_base : hi_base;
    return c.base_only ? b : b + 1;
  endfunction

endpackage

// File: rtl/psc_ctl_sampler.sv
module psc_ctl_sampler
  import psc_pkg::*;
#(
  parameter int unsigned LOW_BASE  = 64,
  parameter int unsigned HIGH_BASE = 128,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow_i,
  input  logic          base_i,
  input  logic          sample_i,
  input  logic          wrap_i,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] half_o
);

  psc_ctl_t      live;
  psc_ctl_t      pend_q;
  logic [CW-1:0] live_len;
  logic [CW-1:0] pend_len;

  assign live     = '{narrow: narrow_i, base_only: base_i};
  assign live_len = CW'(period_len(live, LOW_BASE, HIGH_BASE));
  assign pend_len = CW'(period_len(pend_q, LOW_BASE, HIGH_BASE));

  // Pending pair is captured once per period; the running length is
  // replaced only when the counter wraps, so a period is never cut short.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= live;
      period_o <= live_len;
      half_o   <= live_len >> 1;
    end else begin
      if (sample_i) pend_q <= live;
      if (wrap_i) begin
        period_o <= pend_len;
        half_o   <= pend_len >> 1;
      end
    end
  end

  // R2..R5: the running length is always one of the four legal ratios
  a_r2_legal_length: assert property (@(posedge clk) disable iff (rst)
    (period_o == CW'(LOW_BASE)) || (period_o == CW'(LOW_BASE + 1)) ||
    (period_o == CW'(HIGH_BASE)) || (period_o == CW'(HIGH_BASE + 1)));

endmodule

// File: rtl/psc_phase_counter.sv
module psc_phase_counter #(
  parameter int unsigned CW          = 8,
  parameter int unsigned SAMPLE_LEAD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          sample_o
);

  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] LEAD_GAP = CW'(SAMPLE_LEAD + 1);

  assign wrap_o   = (cnt_o == period_i - ONE);
  assign sample_o = (cnt_o == period_i - LEAD_GAP);

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + ONE;
  end

  // R6: the phase never runs past the running period length
  a_r6_count_below_period: assert property (@(posedge clk) disable iff (rst)
    cnt_o < period_i);

endmodule

// File: rtl/psc_out_shaper.sv
module psc_out_shaper #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] half_i,
  output logic          out_o
);

  // Registered so the downstream counter sees one clean edge per period.
  always_ff @(posedge clk) begin
    if (rst) out_o <= 1'b0;
    else     out_o <= (cnt_i < half_i);
  end

  // R1: reset pulls the output low on the following cycle
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !out_o);

endmodule

// File: rtl/dual_modulus_prescaler.sv
module dual_modulus_prescaler #(
  parameter int unsigned LOW_BASE    = 64,
  parameter int unsigned HIGH_BASE   = 128,
  // Clocks between the sampling edge and the period end, minus one.
  // Must be at least 1 and below LOW_BASE/2.
  parameter int unsigned SAMPLE_LEAD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic range_narrow,
  input  logic mod_base,
  output logic pulse_out
);

  localparam int unsigned CW = $clog2(HIGH_BASE + 2);

  logic [CW-1:0] period;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic          sample;

  psc_ctl_sampler #(
    .LOW_BASE (LOW_BASE),
    .HIGH_BASE(HIGH_BASE),
    .CW       (CW)
  ) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .narrow_i(range_narrow),
    .base_i  (mod_base),
    .sample_i(sample),
    .wrap_i  (wrap),
    .period_o(period),
    .half_o  (half)
  );

  psc_phase_counter #(
    .CW         (CW),
    .SAMPLE_LEAD(SAMPLE_LEAD)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .period_i(period),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .sample_o(sample)
  );

  psc_out_shaper #(
    .CW(CW)
  ) u_shaper (
    .clk   (clk),
    .rst   (rst),
    .cnt_i (cnt),
    .half_i(half),
    .out_o (pulse_out)
  );

  // R7: the ratio only changes as a new period begins
  a_r7_ratio_at_period_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(period) |-> (cnt == '0));

  // R6: the single rising edge sits at phase one of the period
  a_r6_rise_at_phase_one: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> (cnt == CW'(1)));

  // R6: a high output is confined to the first half of the period
  a_r6_high_in_first_half: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> ((cnt != '0) && (cnt <= half)));

endmodule

// File: tb/test_dual_modulus_prescaler.sv
module test_dual_modulus_prescaler;

  localparam int LEAD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic range_narrow = 1'b1;
  logic mod_base = 1'b1;
  logic pulse_out;

  int n_run = 0;
  int n_fail = 0;
  int since_rise = 0;
  int last_gap = 0;
  int high_acc = 0;
  int last_high = 0;
  int ctl_len = 0;
  bit last_out = 1'b0;
  bit rose = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_modulus_prescaler #(.SAMPLE_LEAD(LEAD)) i_dual_modulus_prescaler (
    .clk         (clk),
    .rst         (rst),
    .range_narrow(range_narrow),
    .mod_base    (mod_base),
    .pulse_out   (pulse_out)
  );

  function automatic int plen(bit r, bit m);
    int b;
    b = r ? 64 : 128;
    return m ? b : b + 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One sample per falling edge; tracks rises, gaps and high time.
  task automatic tick();
    @(negedge clk);
    since_rise++;
    rose = 1'b0;
    if (pulse_out && !last_out) begin
      rose      = 1'b1;
      last_gap  = since_rise;
      since_rise = 0;
      last_high = high_acc;
      high_acc  = 1;
    end else if (pulse_out) begin
      high_acc++;
    end
    last_out = pulse_out;
  endtask

  task automatic next_rise(output int waited);
    waited = 0;
    do begin
      tick();
      waited++;
    end while (!rose);
  endtask

  task automatic set_ctl(bit r, bit m);
    range_narrow = r;
    mod_base = m;
  endtask

  task automatic t_reset_start();
    int w;
    rst = 1'b1;
    set_ctl(1'b1, 1'b0);
    repeat (5) tick();
    check("R1", "output during reset", int'(pulse_out), 0);
    rst = 1'b0;
    next_rise(w);
    check("R9", "clocks to first rise", w, 1);
    next_rise(w);
    check("R9", "first period length", last_gap, 65);
    check("R6", "high time of 65", last_high, 32);
    ctl_len = 65;
  endtask

  task automatic t_ratio(bit r, bit m, string req);
    int w;
    int n;
    n = plen(r, m);
    set_ctl(r, m);
    next_rise(w);
    check("R7", "running period kept", last_gap, ctl_len);
    for (int k = 0; k < 2; k++) begin
      next_rise(w);
      check(req, "period length", last_gap, n);
      check("R6", "high time", last_high, n / 2);
    end
    ctl_len = n;
  endtask

  task automatic t_toggle();
    int w;
    bit sr[6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    bit sm[6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    for (int i = 0; i < 6; i++) begin
      set_ctl(sr[i], sm[i]);
      next_rise(w);
      check("R10", "toggled period",
            last_gap, (i == 0) ? ctl_len : plen(sr[i-1], sm[i-1]));
    end
    next_rise(w);
    check("R10", "last toggled period", last_gap, plen(sr[5], sm[5]));
    ctl_len = plen(sr[5], sm[5]);
  endtask

  task automatic t_sample_edge();
    int w;
    set_ctl(1'b1, 1'b1);
    next_rise(w);
    next_rise(w);
    check("R8", "settled 64", last_gap, 64);
    // change seen first on the sampling edge
    repeat (64 - 2 - LEAD) tick();
    set_ctl(1'b1, 1'b0);
    next_rise(w);
    check("R8", "period with on-time change", last_gap, 64);
    next_rise(w);
    check("R8", "on-time change applied", last_gap, 65);
    // change seen first one edge after sampling
    repeat (65 - 1 - LEAD) tick();
    set_ctl(1'b1, 1'b1);
    next_rise(w);
    check("R8", "period with late change", last_gap, 65);
    next_rise(w);
    check("R8", "late change deferred", last_gap, 65);
    next_rise(w);
    check("R8", "late change applied", last_gap, 64);
    ctl_len = 64;
  endtask

  task automatic t_reset_mid();
    int w;
    repeat (20) tick();
    rst = 1'b1;
    set_ctl(1'b0, 1'b0);
    repeat (3) tick();
    check("R1", "output after mid-run reset", int'(pulse_out), 0);
    rst = 1'b0;
    next_rise(w);
    check("R9", "restart first rise", w, 1);
    next_rise(w);
    check("R9", "restart period uses reset controls", last_gap, 129);
    check("R6", "high time of 129", last_high, 64);
    ctl_len = 129;
  endtask

  initial begin
    t_reset_start();
    t_ratio(1'b1, 1'b1, "R2");
    t_ratio(1'b1, 1'b0, "R3");
    t_ratio(1'b0, 1'b1, "R4");
    t_ratio(1'b0, 1'b0, "R5");
    t_toggle();
    t_sample_edge();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule